// File: doc/BRIEF.md
# Interval to Ternary Entry Expander

This block turns a closed numeric interval of 11-bit values into the smallest
list of ternary entries that together match exactly that interval. A ternary
entry is a value plus a don't-care mask. Each entry produced here is a fixed
prefix followed by trailing don't-care bits. Such an entry matches an aligned
block of values whose size is a power of two. The entries are meant to be
written one by one into a ternary CAM. A later search of that CAM with any
value inside the interval then reports the tag stored with the entries.

A request carries one packed interval word, which holds the low and high
bounds, and a tag index. The expansion starts at the low bound and moves
upward. At each step it emits the largest aligned block that starts at the
current value and does not go past the high bound. One entry is produced per
clock cycle. The cycle after the final entry is marked with a single-cycle
completion pulse. If the low bound is above the high bound, no entries are
produced and a single-cycle error pulse is raised instead.

Top module: `range_prefix_gen`

## Requirements
- R1: After reset, `wr_valid`, `done`, `err` and `busy` are all 0.
- R2: In `road_word`, bits 10..0 hold the low bound and bits 21..11 hold the high bound. Both bounds are inclusive.
- R3: An interval whose low bound equals its high bound produces exactly one entry. That entry has `wr_value` equal to the bound and `wr_mask` equal to 0.
- R4: In each entry, a `wr_mask` bit of 1 marks a don't-care bit. The 1s in `wr_mask` form a run that starts at bit 0. The masked bits of `wr_value` are 0. The entries come out in ascending order and do not overlap. Each entry is the largest aligned power-of-two block that starts at the current value and stays within the high bound, so together the entries cover exactly the interval.
- R5: The first entry is on the outputs in the cycle after the cycle in which `start` is accepted. The remaining entries follow in consecutive cycles, with no gaps.
- R6: `done` is 1 for exactly one cycle: the cycle right after the last entry. It is never 1 at the same time as `wr_valid`.
- R7: If the low bound is greater than the high bound, no entry and no `done` are produced. `err` is 1 for exactly one cycle: the cycle after `start` is accepted.
- R8: A `start` that arrives while `busy` is 1 is ignored. The expansion in progress goes on with its own bounds and its own tag, and no extra entries are produced.
- R9: Every entry carries on `wr_road` the `road_sel` value captured when `start` was accepted.
- R10: The interval 0 to 2047 produces one entry with `wr_mask` all 1s and `wr_value` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Requests expansion of `road_word` |
| road_word | input | 22 | Packed interval: high bound in bits 21..11, low bound in bits 10..0 |
| road_sel | input | 6 | Tag index attached to every entry |
| busy | output | 1 | An expansion is in progress |
| wr_valid | output | 1 | An entry is present on the write outputs |
| wr_value | output | 11 | Entry value; the bits under the mask are 0 |
| wr_mask | output | 11 | Entry don't-care mask (1 = don't care) |
| wr_road | output | 6 | Tag index of the entry |
| done | output | 1 | One-cycle pulse after the last entry |
| err | output | 1 | One-cycle pulse for an empty interval |

## Verification
When `start` is accepted at a clock edge, the first entry shows up straight after that edge. An empty interval raises `err` at the same point. Every further entry comes one edge later, and `done` comes one edge after the last entry. The driver checks the first entry, or the error pulse, at the falling edge that follows the accepting edge. The monitor compares every entry at a falling edge against a queue of entries that the driver computed before the request. It also demands that no gap appears before `done`, that `done` arrives only when the queue is empty, and that it comes right after an entry.

// File: rtl/range_prefix_gen.sv
module range_prefix_gen #(
  parameter int W     = 11,
  parameter int IDX_W = 6,
  localparam int CW   = W + 1,
  localparam int KW   = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2*W-1:0]   road_word,
  input  logic [IDX_W-1:0] road_sel,
  output logic             busy,
  output logic             wr_valid,
  output logic [W-1:0]     wr_value,
  output logic [W-1:0]     wr_mask,
  output logic [IDX_W-1:0] wr_road,
  output logic             done,
  output logic             err
);

  logic [CW-1:0] cur;
  logic [W-1:0]  hi;
  logic [KW-1:0] k;
  logic [CW-1:0] step;
  logic          last;

  wire [W-1:0] lo_in = road_word[W-1:0];
  wire [W-1:0] hi_in = road_word[2*W-1:W];
  wire         take  = start && !busy;

  always_comb begin
    logic [CW-1:0] blk;
    k = '0;
    for (int j = 1; j <= W; j++) begin
      blk = CW'(1) << j;
      if (((cur & (blk - 1'b1)) == '0) && (cur + blk - 1'b1 <= {1'b0, hi}))
        k = KW'(j);
    end
  end

  assign step     = CW'(1) << k;
  assign last     = (cur + step - 1'b1) == {1'b0, hi};
  assign wr_valid = busy;
  assign wr_value = cur[W-1:0];
  assign wr_mask  = W'(step - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur     <= '0;
      hi      <= '0;
      wr_road <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (take) begin
        if (lo_in <= hi_in) begin
          busy    <= 1'b1;
          cur     <= {1'b0, lo_in};
          hi      <= hi_in;
          wr_road <= road_sel;
        end else begin
          err <= 1'b1;
        end
      end else if (busy) begin
        cur <= cur + step;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

module range_prefix_gen_chk #(
  parameter int W     = 11,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             wr_valid,
  input logic [W-1:0]     wr_value,
  input logic [W-1:0]     wr_mask,
  input logic [IDX_W-1:0] wr_road,
  input logic             done,
  input logic             err
);

  a_r4_mask_contig: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (((wr_mask + 1'b1) & wr_mask) == '0));

  a_r4_value_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((wr_value & wr_mask) == '0));

  a_r4_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid)) |->
      ({1'b0, wr_value} == {1'b0, $past(wr_value)} + {1'b0, $past(wr_mask)} + 1'b1));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wr_valid && $past(wr_valid)));

  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!wr_valid && !done));

  a_r8_tag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (wr_road == $past(wr_road)));

endmodule

bind range_prefix_gen range_prefix_gen_chk #(.W(W), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/range_prefix_gen_tb.sv
module range_prefix_gen_tb_top;
  localparam int W = 11;
  localparam int IDX_W = 6;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2*W-1:0] road_word = '0;
  logic [IDX_W-1:0] road_sel = '0;
  logic busy, wr_valid, done, err;
  logic [W-1:0] wr_value, wr_mask;
  logic [IDX_W-1:0] wr_road;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [IDX_W+2*W-1:0] expq[$];
  logic prev_valid = 1'b0;
  logic prev_done = 1'b0;
  logic in_run = 1'b0;

  range_prefix_gen #(.W(W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .road_word(road_word),
    .road_sel(road_sel), .busy(busy), .wr_valid(wr_valid),
    .wr_value(wr_value), .wr_mask(wr_mask), .wr_road(wr_road),
    .done(done), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    if (wr_valid) begin
      logic [IDX_W+2*W-1:0] got, exp;
      got = {wr_road, wr_value, wr_mask};
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R4/R8 unexpected entry: actual %h expected none", got);
      end else begin
        exp = expq.pop_front();
        if (got !== exp) begin
          errors++;
          $display("FAIL R4/R9 entry {road,value,mask}: actual %h expected %h", got, exp);
        end
      end
      in_run = 1'b1;
    end else if (in_run && !done) begin
      checks++; errors++;
      $display("FAIL R5 gap in entries: actual valid 0 expected 1");
    end
    if (done) begin
      checks++;
      if (expq.size() != 0 || !prev_valid || prev_done) begin
        errors++;
        $display("FAIL R6 done timing: actual left=%0d prev_valid=%0b expected left=0 prev_valid=1",
                 expq.size(), prev_valid);
      end
      in_run = 1'b0;
    end
    prev_valid = wr_valid;
    prev_done = done;
  end

  task automatic expand(input int lo, input int hi, input int idx);
    int cur = lo;
    while (cur <= hi) begin
      int sz = 1 << W;
      while (sz > 1 && ((cur % sz) != 0 || cur + sz - 1 > hi)) sz = sz / 2;
      expq.push_back({IDX_W'(idx), W'(cur), W'(sz - 1)});
      cur = cur + sz;
    end
  endtask

  task automatic run_road(input int lo, input int hi, input int idx, input int poke_at);
    int n = 0;
    int first_v, first_m;
    logic bad;
    bad = lo > hi;
    if (!bad) expand(lo, hi, idx);
    first_v = lo;
    first_m = bad ? 0 : int'(expq[0][W-1:0]);
    @(negedge clk);
    road_word = {W'(hi), W'(lo)};
    road_sel = IDX_W'(idx);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    checks++;
    if (bad) begin
      if (err !== 1'b1 || wr_valid !== 1'b0) begin
        errors++;
        $display("FAIL R7 empty interval: actual err=%0b valid=%0b expected err=1 valid=0", err, wr_valid);
      end
      @(negedge clk);
      checks++;
      if (err !== 1'b0 || wr_valid !== 1'b0 || done !== 1'b0) begin
        errors++;
        $display("FAIL R7 pulse length: actual err=%0b valid=%0b done=%0b expected 0 0 0", err, wr_valid, done);
      end
    end else begin
      if (wr_valid !== 1'b1 || int'(wr_value) != first_v || int'(wr_mask) != first_m) begin
        errors++;
        $display("FAIL R5 first entry: actual valid=%0b value=%0d expected valid=1 value=%0d",
                 wr_valid, wr_value, first_v);
      end
      while (!done) begin
        n++;
        if (n == poke_at) begin
          road_word = {W'(5), W'(5)};
          road_sel = IDX_W'(idx + 1);
          start = 1'b1;
        end else start = 1'b0;
        @(negedge clk);
      end
      start = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (wr_valid !== 1'b0 || done !== 1'b0 || err !== 1'b0 || busy !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state: actual %b%b%b%b expected 0000", wr_valid, done, err, busy);
    end
    rst_n = 1'b1;
    @(negedge clk);
    run_road(5, 5, 1, 0);          // R3 single value
    run_road(0, 0, 2, 0);          // R3 lowest value
    run_road(2047, 2047, 3, 0);    // R3 highest value
    run_road(0, 2047, 4, 0);       // R10 full span
    run_road(1, 2046, 5, 0);       // R4 many entries
    run_road(3, 100, 6, 0);        // R2 R4
    run_road(1024, 2047, 7, 0);    // R4 aligned half
    run_road(10, 3, 8, 0);         // R7 empty interval
    run_road(100, 900, 9, 4);      // R8 start while busy
    run_road(6, 7, 63, 0);         // R9 tag at the top of its range
    for (int i = 0; i < 6; i++) begin
      int a = int'($urandom_range(0, 2047));
      int b = int'($urandom_range(0, 2047));
      run_road(a < b ? a : b, a < b ? b : a, i + 20, 0);
    end
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R4 missing entries: actual %0d left expected 0", expq.size());
    end
    summary();
  end
endmodule